// File: doc/BRIEF.md
# Triggered Sample Capture Buffer

This block records a bus of digital probe channels into on-chip storage around a trigger event, the core of a simple logic analyser. A slow sample clock arrives as an ordinary signal and is examined on every system clock. A change of that signal in the chosen direction (rising, falling or either) is a sample event. At each sample event while the unit is collecting, the probe bus is written into a circular store. A separate trigger unit supplies a trigger-hit flag, and the unit looks at that flag only on sample events.

Software chooses how many samples make up the window and where the trigger sits in it: first, last, or at a chosen offset. Before the trigger, the store is overwritten in a ring. The trigger is honoured only once enough earlier samples exist to fill the part of the window before it. After the trigger, the rest of the window is filled and then writing stops. The ring position of the trigger sample is latched, so that the readback port returns the window ordered from oldest to newest by a logical index.

In single mode, one window is taken and the result is held. In repeat mode, the unit waits a holdoff period and then rearms by itself. A stop pulse abandons whatever is in progress.

Top module: `trig_capture_buf`

## Requirements
- R1: After reset, armed, triggered and done are all 0, trig_index is 0, and at most one of the three flags is ever 1 at a time.
- R2: A sample event is a change of smp_clk between two consecutive clk cycles, selected by cfg_edge: 2'b00 accepts only a 0-to-1 change, 2'b01 accepts only a 1-to-0 change, and 2'b10 or 2'b11 accepts both. The probe value written is the one present in the cycle of the event.
- R3: The number of samples kept before the trigger, P, is 0 when cfg_tpos is 2'b00, D-1 when cfg_tpos is 2'b01, and min(cfg_pre, D-1) otherwise. P is latched at arm time and shown on trig_index.
- R4: A trigger-hit seen on a sample event is accepted only if at least P sample events have been written since the unit armed. A hit that comes earlier is ignored.
- R5: The trigger sample and the D-P-1 samples after it are written. On the last of these, done rises. No further sample changes the stored window.
- R6: While done is 1, rd_idx = i returns on rd_data, one clk later, the i-th sample of the window counted from the oldest (0 to D-1). Index P is the trigger sample.
- R7: With cfg_auto = 0, the unit stays in the done state, with armed and triggered at 0, until start or stop.
- R8: With cfg_auto = 1, done stays 1 for cfg_holdoff+1 clk cycles after the completing sample. The unit then rearms with the current configuration, and done falls as armed rises.
- R9: A stop pulse puts the unit into idle on the next clk edge from any state, with armed, triggered and done all 0. In idle, sample events have no effect.
- R10: The window length D is cfg_depth, clamped to the range 1 to DEPTH. A value of 0 gives 1, and a value above DEPTH gives DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_clk | input | 1 | Sample clock, examined as a level on every clk |
| probe | input | CH | Probe channels |
| trig_hit | input | 1 | Trigger condition from the external trigger unit |
| cfg_edge | input | 2 | Sample edge select |
| cfg_tpos | input | 2 | Trigger position select |
| cfg_pre | input | AW | User pre-trigger count (AW = log2 DEPTH) |
| cfg_depth | input | DW | Requested window length (DW = log2(DEPTH+1)) |
| cfg_auto | input | 1 | 1 = rearm automatically after each window |
| cfg_holdoff | input | HOLD_W | Holdoff length in clk cycles |
| start | input | 1 | Arm pulse |
| stop | input | 1 | Abort pulse, has priority over start |
| rd_idx | input | AW | Logical readback index, oldest sample is 0 |
| rd_data | output | CH | Stored sample at rd_idx, registered |
| trig_index | output | AW | Logical index of the trigger sample |
| armed | output | 1 | Collecting, waiting for the trigger |
| triggered | output | 1 | Trigger accepted, filling the rest of the window |
| done | output | 1 | Window complete (also during holdoff) |

## Verification
The assertions assume the following about the inputs:
- smp_clk is synchronous to clk and changes at most once in a cycle.
- trig_hit means something only in a cycle with a sample event.
- cfg_auto and cfg_holdoff are stable at the cycle a window completes.
- The other configuration inputs are read only at arm time.

The stimulus keeps within these assumptions. It changes smp_clk on a falling clk edge and then holds it for at least one further cycle. It raises trig_hit only together with an smp_clk change. It alters the configuration only before a start pulse or during an idle stretch of holdoff.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_POST,
    ST_DONE,
    ST_HOLD
  } cap_state_t;

  localparam logic [1:0] EDGE_RISE  = 2'b00;
  localparam logic [1:0] EDGE_FALL  = 2'b01;
  localparam logic [1:0] TPOS_FIRST = 2'b00;
  localparam logic [1:0] TPOS_LAST  = 2'b01;

  // window length after clamping to 1..maxd
  function automatic int clamp_depth(int req, int maxd);
    if (req < 1) return 1;
    if (req > maxd) return maxd;
    return req;
  endfunction

  // samples kept ahead of the trigger
  function automatic int window_pre(logic [1:0] tpos, int user, int depth);
    if (tpos == TPOS_FIRST) return 0;
    if (tpos == TPOS_LAST) return depth - 1;
    return (user > depth - 1) ? depth - 1 : user;
  endfunction

  // ring position reached from base by off steps
  function automatic int ring_index(int base, int off, int depth);
    return (base + off) % depth;
  endfunction

endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_clk,
  input  logic [1:0] edge_sel,
  output logic       sample_evt
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= smp_clk;
  end

  always_comb begin
    case (edge_sel)
      EDGE_RISE: sample_evt = smp_clk & ~prev_q;
      EDGE_FALL: sample_evt = ~smp_clk & prev_q;
      default:   sample_evt = smp_clk ^ prev_q;
    endcase
  end

  assert_event_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (smp_clk != prev_q));

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int HOLD_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_evt,
  input  logic              trig_hit,
  input  logic [1:0]        cfg_tpos,
  input  logic [AW-1:0]     cfg_pre,
  input  logic [DW-1:0]     cfg_depth,
  input  logic              cfg_auto,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  input  logic              start,
  input  logic              stop,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     trig_addr,
  output logic [DW-1:0]     win_depth,
  output logic [AW-1:0]     win_pre,
  output logic              armed,
  output logic              triggered,
  output logic              done
);

  cap_state_t        state;
  logic [AW-1:0]     wr_ptr;
  logic [DW-1:0]     precnt;
  logic [DW-1:0]     postcnt;
  logic [HOLD_W-1:0] hold_cnt;

  // named internal events
  logic [DW-1:0] arm_depth;
  logic [AW-1:0] arm_pre;
  logic [DW-1:0] post_need;
  logic [AW-1:0] nxt_ptr;
  logic          trig_accept;
  logic          cap_complete;
  logic          rearm_now;

  always_comb begin
    arm_depth = DW'(clamp_depth(int'(cfg_depth), DEPTH));
    arm_pre   = AW'(window_pre(cfg_tpos, int'(cfg_pre), clamp_depth(int'(cfg_depth), DEPTH)));
    post_need = win_depth - DW'(win_pre);
    nxt_ptr   = (DW'(wr_ptr) == win_depth - DW'(1)) ? '0 : wr_ptr + AW'(1);
    wr_en     = sample_evt && (state == ST_ARMED || state == ST_POST);
    trig_accept = wr_en && (state == ST_ARMED) && trig_hit && (precnt >= DW'(win_pre));
    cap_complete = (trig_accept && post_need == DW'(1)) ||
                   (wr_en && state == ST_POST && (postcnt + DW'(1)) == post_need);
    rearm_now = (state == ST_HOLD) && (hold_cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_ptr    <= '0;
      precnt    <= '0;
      postcnt   <= '0;
      hold_cnt  <= '0;
      trig_addr <= '0;
      win_depth <= DW'(1);
      win_pre   <= '0;
    end else if (stop) begin
      state <= ST_IDLE;
    end else if (start || rearm_now) begin
      state     <= ST_ARMED;
      win_depth <= arm_depth;
      win_pre   <= arm_pre;
      wr_ptr    <= '0;
      precnt    <= '0;
      postcnt   <= '0;
    end else begin
      if (wr_en) wr_ptr <= nxt_ptr;
      case (state)
        ST_ARMED: begin
          if (trig_accept) begin
            trig_addr <= wr_ptr;
            postcnt   <= DW'(1);
            state     <= ST_POST;
          end else if (wr_en && precnt < DW'(DEPTH)) begin
            precnt <= precnt + DW'(1);
          end
        end
        ST_POST: begin
          if (wr_en) postcnt <= postcnt + DW'(1);
        end
        ST_HOLD: hold_cnt <= hold_cnt - HOLD_W'(1);
        default: ;
      endcase
      if (cap_complete) begin
        state    <= cfg_auto ? ST_HOLD : ST_DONE;
        hold_cnt <= cfg_holdoff;
      end
    end
  end

  assign wr_addr   = wr_ptr;
  assign armed     = (state == ST_ARMED);
  assign triggered = (state == ST_POST);
  assign done      = (state == ST_DONE) || (state == ST_HOLD);

  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, triggered, done}));

  assert_pre_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    DW'(win_pre) < win_depth);

  assert_trig_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggered) |-> $past(armed && sample_evt && trig_hit && (precnt >= DW'(win_pre))));

  assert_post_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    triggered |-> (postcnt < post_need));

  assert_done_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en));

  assert_hold_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_now && !stop) |=> armed);

  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!armed && !triggered && !done));

  assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed || triggered) |-> (DW'(wr_ptr) < win_depth));

endmodule

// File: rtl/cap_mem.sv
module cap_mem
  import cap_pkg::*;
#(
  parameter int CH    = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CH-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  input  logic [AW-1:0] trig_addr,
  input  logic [DW-1:0] win_depth,
  input  logic [AW-1:0] win_pre,
  output logic [CH-1:0] rd_data
);

  logic [CH-1:0] store [DEPTH];
  logic [AW-1:0] rd_phys;

  // oldest sample sits win_pre positions before the trigger, modulo the ring
  always_comb begin
    rd_phys = AW'(ring_index(int'(trig_addr),
                             int'(win_depth) - int'(win_pre) + int'(rd_idx),
                             int'(win_depth)));
  end

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= store[rd_phys];
  end

  assert_read_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
    DW'(rd_phys) < win_depth);

endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf
  import cap_pkg::*;
#(
  parameter int CH     = 16,
  parameter int DEPTH  = 64,
  parameter int HOLD_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_clk,
  input  logic [CH-1:0]     probe,
  input  logic              trig_hit,
  input  logic [1:0]        cfg_edge,
  input  logic [1:0]        cfg_tpos,
  input  logic [AW-1:0]     cfg_pre,
  input  logic [DW-1:0]     cfg_depth,
  input  logic              cfg_auto,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  input  logic              start,
  input  logic              stop,
  input  logic [AW-1:0]     rd_idx,
  output logic [CH-1:0]     rd_data,
  output logic [AW-1:0]     trig_index,
  output logic              armed,
  output logic              triggered,
  output logic              done
);

  logic          sample_evt;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] trig_addr;
  logic [DW-1:0] win_depth;
  logic [AW-1:0] win_pre;

  cap_edge_detect u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_clk    (smp_clk),
    .edge_sel   (cfg_edge),
    .sample_evt (sample_evt)
  );

  cap_ctrl #(.DEPTH(DEPTH), .HOLD_W(HOLD_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_evt  (sample_evt),
    .trig_hit    (trig_hit),
    .cfg_tpos    (cfg_tpos),
    .cfg_pre     (cfg_pre),
    .cfg_depth   (cfg_depth),
    .cfg_auto    (cfg_auto),
    .cfg_holdoff (cfg_holdoff),
    .start       (start),
    .stop        (stop),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .trig_addr   (trig_addr),
    .win_depth   (win_depth),
    .win_pre     (win_pre),
    .armed       (armed),
    .triggered   (triggered),
    .done        (done)
  );

  cap_mem #(.CH(CH), .DEPTH(DEPTH)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (probe),
    .rd_idx    (rd_idx),
    .trig_addr (trig_addr),
    .win_depth (win_depth),
    .win_pre   (win_pre),
    .rd_data   (rd_data)
  );

  assign trig_index = win_pre;

endmodule

// File: tb/trig_capture_buf_test.sv
module trig_capture_buf_test;

  localparam int CH = 16;
  localparam int DEPTH = 8;
  localparam int HOLD_W = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int DW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_clk = 1'b0;
  logic [CH-1:0] probe = '0;
  logic trig_hit = 1'b0;
  logic [1:0] cfg_edge = 2'b00;
  logic [1:0] cfg_tpos = 2'b00;
  logic [AW-1:0] cfg_pre = '0;
  logic [DW-1:0] cfg_depth = '0;
  logic cfg_auto = 1'b0;
  logic [HOLD_W-1:0] cfg_holdoff = '0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic [AW-1:0] rd_idx = '0;
  logic [CH-1:0] rd_data;
  logic [AW-1:0] trig_index;
  logic armed, triggered, done;

  trig_capture_buf #(.CH(CH), .DEPTH(DEPTH), .HOLD_W(HOLD_W)) uut (
    .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .probe(probe), .trig_hit(trig_hit),
    .cfg_edge(cfg_edge), .cfg_tpos(cfg_tpos), .cfg_pre(cfg_pre), .cfg_depth(cfg_depth),
    .cfg_auto(cfg_auto), .cfg_holdoff(cfg_holdoff), .start(start), .stop(stop),
    .rd_idx(rd_idx), .rd_data(rd_data), .trig_index(trig_index),
    .armed(armed), .triggered(triggered), .done(done)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int tag = 0;
  int cur_phase = 0;
  int ev_tag [0:1023];
  int ev_n;
  int trig_k;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  task automatic chk(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // trigger unit model: hit on every fifth toggle, shifted by phase
  function automatic bit hit_at(int t, int ph);
    return ((t + ph) % 5) == 0;
  endfunction

  function automatic int bench_depth(int req);
    int d;
    d = req;
    if (d > DEPTH) d = DEPTH;
    if (d == 0) d = 1;
    return d;
  endfunction

  function automatic int bench_pre(int tp, int user, int d);
    if (tp == 0) return 0;
    if (tp == 1) return d - 1;
    if (user >= d) return d - 1;
    return user;
  endfunction

  task automatic do_toggle(input int edg, output bit is_ev);
    @(negedge clk);
    smp_clk = ~smp_clk;
    tag++;
    probe = 16'(tag);
    trig_hit = hit_at(tag, cur_phase);
    if (edg == 0) is_ev = smp_clk;
    else if (edg == 1) is_ev = !smp_clk;
    else is_ev = 1'b1;
    @(negedge clk);
    trig_hit = 1'b0;
  endtask

  task automatic run_capture(input int dreq, input int tp, input int upre, input int edg,
                             input bit auto_m, input bit do_start,
                             output int exp_d, output int exp_p);
    bit e;
    bit fin;
    int guard;
    exp_d = bench_depth(dreq);
    exp_p = bench_pre(tp, upre, exp_d);
    if (do_start) begin
      @(negedge clk);
      cfg_depth = DW'(dreq);
      cfg_tpos = 2'(tp);
      cfg_pre = AW'(upre);
      cfg_edge = 2'(edg);
      cfg_auto = auto_m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    ev_n = 0;
    trig_k = -1;
    fin = 0;
    guard = 0;
    while (!fin && guard < 600) begin
      do_toggle(edg, e);
      if (e) begin
        ev_tag[ev_n] = tag;
        if (trig_k < 0 && ev_n >= exp_p && hit_at(tag, cur_phase)) trig_k = ev_n;
        ev_n++;
        if (trig_k >= 0 && (ev_n - trig_k) == (exp_d - exp_p)) fin = 1;
      end
      guard++;
    end
  endtask

  task automatic check_window(input int dreq, input int exp_d, input int exp_p,
                              input int edg, input bit extra);
    bit e;
    string lbl;
    if (extra) for (int x = 0; x < 3; x++) do_toggle(edg, e);
    chk(int'(done), 1, "R5 done after window");
    chk(int'(armed), 0, "R7 single mode not rearmed");
    chk(int'(triggered), 0, "R7 triggered clear when done");
    chk(int'(trig_index), exp_p, "R3 trigger index");
    lbl = (dreq < 1 || dreq > DEPTH) ? "R10 clamped window readback" : "R2 R4 R6 ordered readback";
    for (int i = 0; i < exp_d; i++) begin
      @(negedge clk);
      rd_idx = AW'(i);
      @(negedge clk);
      chk(int'(rd_data), ev_tag[trig_k - exp_p + i] & 16'hFFFF, lbl);
    end
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    int ed, ep;
    bit e;
    repeat (3) @(negedge clk);
    chk(int'(armed), 0, "R1 armed in reset");
    chk(int'(done), 0, "R1 done in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'({armed, triggered, done}), 0, "R1 flags after reset");
    chk(int'(trig_index), 0, "R1 trig_index after reset");

    // sweep of depth, trigger position and edge mode in single mode
    for (int dreq = 0; dreq <= DEPTH + 1; dreq++) begin
      for (int tpi = 0; tpi < 10; tpi++) begin
        for (int edg = 0; edg < 3; edg++) begin
          cur_phase = (dreq * 3 + tpi + edg) % 5;
          run_capture(dreq, (tpi < 2) ? tpi : 2, (tpi < 2) ? 0 : tpi - 2, edg, 1'b0, 1'b1, ed, ep);
          check_window(dreq, ed, ep, edg, 1'b1);
        end
      end
    end

    // R7: result held in single mode
    repeat (20) @(negedge clk);
    chk(int'(done), 1, "R7 done held");
    chk(int'(armed), 0, "R7 still not armed");

    // R8: automatic rearm after holdoff
    cfg_holdoff = 16'd4;
    cur_phase = 2;
    run_capture(3, 1, 0, 2, 1'b1, 1'b1, ed, ep);
    chk(int'(done), 1, "R8 done at holdoff start");
    for (int j = 2; j <= 5; j++) begin
      @(negedge clk);
      chk(int'(done), 1, "R8 done during holdoff");
      chk(int'(armed), 0, "R8 not armed during holdoff");
    end
    cfg_auto = 1'b0;
    @(negedge clk);
    chk(int'(armed), 1, "R8 rearmed after holdoff");
    chk(int'(done), 0, "R8 done cleared on rearm");
    run_capture(3, 1, 0, 2, 1'b0, 1'b0, ed, ep);
    check_window(3, ed, ep, 2, 1'b1);

    // R9: stop while armed
    cur_phase = 1;
    run_capture(8, 1, 0, 2, 1'b0, 1'b1, ed, ep);
    @(negedge clk);
    cfg_tpos = 2'b01;
    cfg_depth = DW'(8);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int x = 0; x < 3; x++) do_toggle(2, e);
    chk(int'(armed), 1, "R9 armed before stop");
    pulse_stop();
    chk(int'({armed, triggered, done}), 0, "R9 idle after stop when armed");

    // R9: stop while filling after the trigger
    cfg_tpos = 2'b00;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int x = 0; x < 12 && !triggered; x++) do_toggle(2, e);
    chk(int'(triggered), 1, "R9 triggered before stop");
    pulse_stop();
    chk(int'({armed, triggered, done}), 0, "R9 idle after stop when triggered");
    for (int x = 0; x < 6; x++) do_toggle(2, e);
    chk(int'({armed, triggered, done}), 0, "R9 samples ignored in idle");

    // R9: stop from the done state
    cur_phase = 0;
    run_capture(2, 0, 0, 0, 1'b0, 1'b1, ed, ep);
    chk(int'(done), 1, "R5 done before stop");
    pulse_stop();
    chk(int'(done), 0, "R9 done cleared by stop");

    finished = 1;
    report();
    $finish;
  end

endmodule